// File: doc/BRIEF.md
# Pulse-Swallow Multi-Modulus Clock Divider

This block divides a fast clock by a programmable integer ratio, built the way frequency-synthesizer dividers are: a small dual-modulus prescaler that divides by either N or N+1, driven by one shared down counter. The shared counter does two jobs. It tells the prescaler when to stop swallowing extra cycles, and it marks the end of each division period. The output is a single one-cycle strobe once per period. The period is N·T + E fast-clock cycles, where T is the total count of prescaler cycles in a period and E is the number of those cycles that run at N+1.

At every period boundary the divider latches T and the difference T−E. Software or a loop controller can therefore rewrite the counts at any time, and the period already under way runs to completion with the counts it started with. While the prescaler divides by N, its extra swallow stage holds its state and is not clocked. A parameter sets the polarity of the prescaler's modulus select, and the top adapts the counter's phase flag to that polarity so that the swallow phase always comes first.

Top module: `pswallow_div`

## Requirements
- R1: With 1 ≤ `cnt_total_i` ≤ 2^W−1 and 0 ≤ `cnt_ext_i` ≤ `cnt_total_i` held steady, successive rising edges of `div_o` are exactly N·T + E fast-clock cycles apart (T = `cnt_total_i`, E = `cnt_ext_i`; 18 cycles for N=2, T=7, E=4).
- R2: Within a period the first E prescaler cycles last N+1 clocks and the remaining T−E last N. At the edges of the range, E=0 gives a period of N·T and E=T gives (N+1)·T.
- R3: `div_o` is high for exactly one fast-clock cycle per period.
- R4: `cnt_total_i` and `cnt_ext_i` are sampled only on the clock edge that raises `div_o`. A change made part way through a period leaves that period's length unchanged and takes effect in the next period.
- R5: While `rst_n` is low, `div_o` is 0. After `rst_n` rises, `div_o` first goes high following rising edge number N·T + E + 3: two edges for the reset synchronizer, one load edge, then one full period.
- R6: While the prescaler divides by N, its swallow stage stays in its idle state.
- R7: The prescaler's modulus changes only on the edge that ends a prescaler cycle. The swallow stage, once it is set, ends that prescaler cycle on the next clock.
- R8: The smallest programming in regular use, T=3 and E=2, gives a period of 8 cycles with N=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_total_i | input | W | Total prescaler cycles per period (T) |
| cnt_ext_i | input | W | Prescaler cycles per period that divide by N+1 (E) |
| div_o | output | 1 | One-cycle strobe per division period |

## Verification
The bench builds the divider with N=2, W=8 and the default select polarity. With these values every ratio from 2 to 765 is reachable, and both range edges (E=0 and E=T) can be tested, together with the maximum count of 255 and the minimum count of 1. The narrow W also lets a full-scale period finish within a short run. Mid-period reprogramming and a reset applied mid-run are timed against the fixed synchronizer and load latency.

// File: rtl/pswallow_div_pkg.sv
package pswallow_div_pkg;

  // Expected period in fast-clock cycles for a given prescaler base and counts.
  function automatic int unsigned period_len(input int unsigned n,
                                             input int unsigned t,
                                             input int unsigned e);
    return n * t + e;
  endfunction

  // Counter phase flag encoding: low during swallow, high once swallowing ends.
  typedef enum logic {
    PH_SWALLOW = 1'b0,
    PH_PLAIN   = 1'b1
  } phase_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned N           = 2,
  parameter bit          PLUS1_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sel_i,
  output logic tick_o,
  output logic ext_o
);

  localparam int unsigned BW = (N > 2) ? $clog2(N) : 1;
  localparam logic [BW-1:0] LAST = BW'(N - 1);

  logic [BW-1:0] base_q, base_d;
  logic          ext_q, ext_d, ext_en;
  logic          plus1, at_last;

  assign plus1   = (sel_i == PLUS1_LEVEL);
  assign at_last = (base_q == LAST);
  assign tick_o  = run_i & at_last & (~plus1 | ext_q);
  assign ext_o   = ext_q;

  // The swallow stage is only clocked when it can matter: in N+1 mode,
  // while it is set, or while the block is idle and being cleared.
  assign ext_en = ~run_i | plus1 | ext_q;

  always_comb begin
    base_d = base_q;
    ext_d  = ext_q;
    if (!run_i) begin
      base_d = '0;
      ext_d  = 1'b0;
    end else if (tick_o) begin
      base_d = '0;
      ext_d  = 1'b0;
    end else if (at_last) begin
      ext_d  = 1'b1;
    end else begin
      base_d = base_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
    end else if (ext_en) begin
      ext_q <= ext_d;
    end
  end

endmodule

// File: rtl/psd_share_cnt.sv
module psd_share_cnt
  import pswallow_div_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic [W-1:0] tot_i,
  input  logic [W-1:0] ext_i,
  output logic         done_o,
  output logic         end_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] dif_q, dif_d;
  phase_e       ph_q, ph_d;
  logic         end_q, end_d;
  logic [W-1:0] dif_new, nxt;
  logic         wrap, hit, cnt_en;

  assign dif_new = tot_i - ext_i;
  assign nxt     = cnt_q - 1'b1;
  assign wrap    = tick_i & (nxt == '0);
  assign hit     = (nxt == dif_q);
  assign cnt_en  = load_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    dif_d = dif_q;
    ph_d  = ph_q;
    end_d = 1'b0;
    if (load_i || wrap) begin
      cnt_d = tot_i;
      dif_d = dif_new;
      ph_d  = (ext_i == '0) ? PH_PLAIN : PH_SWALLOW;
      end_d = wrap;
    end else if (tick_i) begin
      cnt_d = nxt;
      if (hit) begin
        ph_d = PH_PLAIN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dif_q <= '0;
      ph_q  <= PH_SWALLOW;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      dif_q <= dif_d;
      ph_q  <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
    end else begin
      end_q <= end_d;
    end
  end

  assign done_o = (ph_q == PH_PLAIN);
  assign end_o  = end_q;

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned N           = 2,
  parameter int unsigned W           = 8,
  parameter bit          PLUS1_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_total_i,
  input  logic [W-1:0] cnt_ext_i,
  output logic         div_o
);

  logic sync1_q, sync2_q, srst_n;
  logic run_q;
  logic tick, ext_busy, done, sel;

  // Reset: asserted asynchronously, released through two flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign srst_n = sync2_q;

  // One load cycle after reset before the prescaler starts.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
    end
  end

  // Map the counter's phase flag onto the prescaler's select sense.
  generate
    if (PLUS1_LEVEL) begin : g_sel_hi
      assign sel = ~done;
    end else begin : g_sel_lo
      assign sel = done;
    end
  endgenerate

  psd_prescaler #(.N(N), .PLUS1_LEVEL(PLUS1_LEVEL)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .run_i (run_q),
    .sel_i (sel),
    .tick_o(tick),
    .ext_o (ext_busy)
  );

  psd_share_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (srst_n),
    .load_i(~run_q),
    .tick_i(tick),
    .tot_i (cnt_total_i),
    .ext_i (cnt_ext_i),
    .done_o(done),
    .end_o (div_o)
  );

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk (
  input logic clk,
  input logic srst_n,
  input logic run_q,
  input logic tick,
  input logic ext_busy,
  input logic done,
  input logic div_o
);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!srst_n)
    div_o |=> !div_o);

  // R1
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(div_o) |-> $past(tick));

  // R6
  swallow_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !ext_busy) |=> !ext_busy);

  // R7
  mode_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (run_q && $past(run_q) && (done != $past(done))) |-> $past(tick));

  // R7
  ext_then_tick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ext_busy |-> tick);

endmodule

bind pswallow_div pswallow_div_chk u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .run_q   (run_q),
  .tick    (tick),
  .ext_busy(ext_busy),
  .done    (done),
  .div_o   (div_o)
);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
  localparam int N = 2;
  localparam int W = 8;
  localparam int NV = 9;
  // columns: total count, extended count, expected period
  localparam int VEC [NV][3] = '{
    '{7,   4,   18},   // R1 nominal
    '{3,   2,   8},    // R8 minimum
    '{5,   0,   10},   // R2 no swallow
    '{6,   6,   18},   // R2 all swallow
    '{1,   0,   2},    // R1 shortest
    '{1,   1,   3},    // R2
    '{20,  7,   47},   // R1
    '{255, 3,   513},  // R1 full-scale count
    '{255, 255, 765}   // R2 full-scale swallow
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tot_cfg = 8'd7;
  logic [W-1:0] ext_cfg = 8'd4;
  logic         div_o;
  int           total = 0;
  int           bad = 0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  pswallow_div #(.N(N), .W(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_total_i(tot_cfg),
    .cnt_ext_i  (ext_cfg),
    .div_o      (div_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts falling edges up to and including the next one that sees div_o high.
  task automatic measure(output int n, output int first_lvl);
    n = 0;
    first_lvl = -1;
    do begin
      @(negedge clk);
      n++;
      if (first_lvl < 0) first_lvl = int'(div_o);
    end while (div_o !== 1'b1);
  endtask

  initial begin
    int n, lvl;
    // R5: output idle under reset
    repeat (3) @(negedge clk);
    check("R5 div_o during reset", int'(div_o), 0);
    rst_n = 1'b1;
    measure(n, lvl);
    check("R5 first pulse latency", n, 7 * N + 4 + 3);

    // Table walk: new counts apply after the next boundary.
    for (int i = 0; i < NV; i++) begin
      tot_cfg = VEC[i][0][W-1:0];
      ext_cfg = VEC[i][1][W-1:0];
      measure(n, lvl);
      measure(n, lvl);
      check($sformatf("R1 period T=%0d E=%0d", VEC[i][0], VEC[i][1]), n, VEC[i][2]);
      check("R3 pulse low after one cycle", lvl, 0);
      measure(n, lvl);
      check($sformatf("R2 repeat period T=%0d E=%0d", VEC[i][0], VEC[i][1]), n, VEC[i][2]);
    end

    // R4: change mid-period
    tot_cfg = 8'd7; ext_cfg = 8'd4;
    measure(n, lvl);
    measure(n, lvl);
    repeat (3) @(negedge clk);
    tot_cfg = 8'd3; ext_cfg = 8'd2;
    measure(n, lvl);
    check("R4 current period kept", n + 3, 18);
    measure(n, lvl);
    check("R4 new counts next period", n, 8);
    check("R8 minimum programming", n, 8);

    // R5: reset mid-run
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 div_o after mid-run reset", int'(div_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    measure(n, lvl);
    check("R5 latency after mid-run reset", n, 3 * N + 2 + 3);
    check("R3 no early pulse after reset", lvl, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule